// File: doc/BRIEF.md
# PCIe PHY Power-Up Sequencer

This block brings a PCIe PHY out of reset and through its PLL start-up. A single-cycle power-on request releases the PHY reset, points the PHY configuration port at the PLL-lock status view and takes lane 0 out of idle. The sequencer then polls the lock flag, programs two PHY configuration registers through a small write engine, waits for the PLL output flag to drop, points the port back at the lock view and polls for lock once more. When all four stages succeed, the block reports ready.

Every wait stage samples its flag once per poll interval and gives up after a fixed timeout. A timeout puts the PHY back in reset and latches a 2-bit code that names the stage that failed. A power-off request first forces lane 0 to idle and then asserts the reset on the next cycle. The same actions abort a power-on sequence that is still running. The poll interval, the timeout and the write engine's setup and strobe time are parameters in clock cycles. Their defaults match a 50 µs poll and a 20 ms limit at 50 MHz.

Top module: `phy_pwrup_seq`

## Requirements
- R1: After reset, phyRst=1, laneIdle=1, cfgWe=0, cfgAddr=0, cfgData=0, ready=0, busy=0 and errCode=0.
- R2: When powerOnReq is sampled high in the idle state, the next clock edge sets phyRst=0, laneIdle=0, cfgAddr=0x10 and busy=1, and clears errCode to 0.
- R3: The first wait samples pllLocked once every POLL_CYCLES cycles. If lock is seen before TIMEOUT_CYCLES cycles have passed, the sequence continues. If not, the stage fails with errCode=1, about TIMEOUT_CYCLES cycles after the request.
- R4: After the first lock, two configuration writes follow in this order: address 0x10 with data 0x8, then address 0x12 with data 0x8. For each write, address and data are set WR_GAP_CYCLES cycles before cfgWe rises, cfgWe stays high for WR_GAP_CYCLES cycles, and address and data hold steady while cfgWe is high.
- R5: After the writes, the block waits for pllOutput to read 0, with the same poll interval and limit. A timeout in this stage gives errCode=2.
- R6: Once pllOutput is 0, cfgAddr returns to 0x10 and pllLocked is polled again. Success sets ready=1 and busy=0. A timeout in this stage gives errCode=3.
- R7: On any timeout, phyRst=1, busy=0 and ready=0. The error code holds until the next accepted power-on request, which clears it to 0.
- R8: When powerOffReq is sampled high, the next edge sets laneIdle=1 and clears ready. The edge after that sets phyRst=1 and returns busy to 0.
- R9: A powerOffReq during power-on aborts the sequence with the R8 actions. No further configuration write is issued, and errCode stays 0.
- R10: A powerOnReq while ready=1 is ignored: ready stays 1 and no configuration write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| powerOnReq | input | 1 | Single-cycle power-on request |
| powerOffReq | input | 1 | Single-cycle power-off request, takes priority |
| pllLocked | input | 1 | PLL lock status flag from the PHY |
| pllOutput | input | 1 | PLL output status flag; power-up waits for it to read 0 |
| phyRst | output | 1 | PHY reset, 1 = held in reset |
| laneIdle | output | 1 | Lane 0 idle control, 1 = idle |
| cfgAddr | output | 6 | PHY configuration address |
| cfgData | output | 4 | PHY configuration write data |
| cfgWe | output | 1 | PHY configuration write strobe |
| ready | output | 1 | Power-up finished successfully |
| busy | output | 1 | Power-on or power-off sequence in progress |
| errCode | output | 2 | 0 = none, 1 = lock, 2 = output-clear, 3 = relock timeout |

## Verification
The assertions watch four things on every cycle. The configuration address and data stay steady while the write strobe is high. A latched error always comes with the PHY in reset. A new error code appears only after the last poll of a wait has been used. A reset rise that is not a failure is always preceded by lane idle, and ready never coexists with reset or idle. Only the bench scenarios can show the things that depend on the PLL model's timing: the exact write order and values, which stage's timeout yields which code, how close to the limit a late lock can still succeed, and that an abort or a repeated request issues no further write.

// File: rtl/phy_pwrup_pkg.sv
package phy_pwrup_pkg;

  localparam logic [5:0] ADDR_PLL_VIEW = 6'h10;
  localparam logic [5:0] ADDR_CLK_SRC  = 6'h12;
  localparam logic [3:0] DATA_RATE     = 4'h8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WAIT_LOCK, ST_WR_A_SET, ST_WR_A_STB, ST_WR_B_SET, ST_WR_B_STB,
    ST_WAIT_OCLR, ST_WAIT_RELOCK, ST_ON, ST_OFF
  } seqState_e;

  typedef enum logic [1:0] {SEL_STATUS, SEL_WR_A, SEL_WR_B} cfgSel_e;

  typedef struct packed {
    logic    relRst;
    logic    setRst;
    logic    clrIdle;
    logic    setIdle;
    logic    cfgLoad;
    cfgSel_e cfgSel;
    logic    weOn;
    logic    weOff;
    logic    tmrStart;
    logic    tmrGap;
    logic    tmrReload;
    logic    errSet;
    logic [1:0] errVal;
    logic    errClr;
  } seqCtrl_t;

endpackage

// File: rtl/phy_pwrup_dp.sv
module phy_pwrup_dp
  import phy_pwrup_pkg::*;
#(
  parameter int POLL_CYCLES    = 2500,
  parameter int TIMEOUT_CYCLES = 1000000,
  parameter int WR_GAP_CYCLES  = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  seqCtrl_t   ctrl,
  output logic       tick,
  output logic       pollLast,
  output logic       phyRst,
  output logic       laneIdle,
  output logic [5:0] cfgAddr,
  output logic [3:0] cfgData,
  output logic       cfgWe,
  output logic [1:0] errCode
);

  localparam int MAX_POLLS = (TIMEOUT_CYCLES / POLL_CYCLES) > 0 ? (TIMEOUT_CYCLES / POLL_CYCLES) : 1;
  localparam int IDX_W     = MAX_POLLS > 1 ? $clog2(MAX_POLLS) : 1;
  localparam int TMR_MAX   = POLL_CYCLES > WR_GAP_CYCLES ? POLL_CYCLES : WR_GAP_CYCLES;
  localparam int TMR_W     = TMR_MAX > 1 ? $clog2(TMR_MAX) : 1;

  logic [TMR_W-1:0] tmr;
  logic [IDX_W-1:0] pollIdx;

  assign tick     = (tmr == '0);
  assign pollLast = (pollIdx == IDX_W'(MAX_POLLS - 1));

  // Shared interval timer: poll period or write-engine gap
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr     <= '0;
      pollIdx <= '0;
    end else if (ctrl.tmrStart) begin
      tmr     <= ctrl.tmrGap ? TMR_W'(WR_GAP_CYCLES - 1) : TMR_W'(POLL_CYCLES - 1);
      pollIdx <= '0;
    end else if (ctrl.tmrReload) begin
      tmr     <= TMR_W'(POLL_CYCLES - 1);
      pollIdx <= pollIdx + 1'b1;
    end else if (tmr != '0) begin
      tmr <= tmr - 1'b1;
    end
  end

  // PHY-facing control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phyRst   <= 1'b1;
      laneIdle <= 1'b1;
      cfgAddr  <= '0;
      cfgData  <= '0;
      cfgWe    <= 1'b0;
      errCode  <= '0;
    end else begin
      if (ctrl.relRst)      phyRst <= 1'b0;
      else if (ctrl.setRst) phyRst <= 1'b1;

      if (ctrl.clrIdle)      laneIdle <= 1'b0;
      else if (ctrl.setIdle) laneIdle <= 1'b1;

      if (ctrl.cfgLoad) begin
        case (ctrl.cfgSel)
          SEL_STATUS: cfgAddr <= ADDR_PLL_VIEW;
          SEL_WR_A: begin
            cfgAddr <= ADDR_PLL_VIEW;
            cfgData <= DATA_RATE;
          end
          SEL_WR_B: begin
            cfgAddr <= ADDR_CLK_SRC;
            cfgData <= DATA_RATE;
          end
          default: ;
        endcase
      end

      if (ctrl.weOn)       cfgWe <= 1'b1;
      else if (ctrl.weOff) cfgWe <= 1'b0;

      if (ctrl.errClr)      errCode <= '0;
      else if (ctrl.errSet) errCode <= ctrl.errVal;
    end
  end

  AST_WE_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWe && $past(cfgWe)) |-> ($stable(cfgAddr) && $stable(cfgData))); // R4

  AST_ERR_HOLDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (errCode != 2'd0) |-> phyRst); // R7

  AST_ERR_AFTER_LAST_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    ((errCode != 2'd0) && ($past(errCode) == 2'd0)) |-> ($past(pollIdx) == IDX_W'(MAX_POLLS - 1))); // R3

  AST_IDLE_BEFORE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(phyRst) && (errCode == 2'd0)) |-> $past(laneIdle)); // R8

endmodule

// File: rtl/phy_pwrup_ctrl.sv
module phy_pwrup_ctrl
  import phy_pwrup_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     powerOnReq,
  input  logic     powerOffReq,
  input  logic     pllLocked,
  input  logic     pllOutput,
  input  logic     tick,
  input  logic     pollLast,
  output seqCtrl_t ctrl,
  output logic     ready,
  output logic     busy
);

  seqState_e state, nxt;
  logic      waitOk;
  logic [1:0] waitCode;

  always_comb begin
    waitOk   = 1'b0;
    waitCode = 2'd0;
    case (state)
      ST_WAIT_LOCK:   begin waitOk = pllLocked;  waitCode = 2'd1; end
      ST_WAIT_OCLR:   begin waitOk = !pllOutput; waitCode = 2'd2; end
      ST_WAIT_RELOCK: begin waitOk = pllLocked;  waitCode = 2'd3; end
      default: ;
    endcase
  end

  always_comb begin
    ctrl = '0;
    nxt  = state;
    if (powerOffReq && state != ST_OFF) begin
      ctrl.setIdle = 1'b1;
      ctrl.weOff   = 1'b1;
      nxt          = ST_OFF;
    end else begin
      case (state)
        ST_IDLE: if (powerOnReq) begin
          ctrl.relRst   = 1'b1;
          ctrl.clrIdle  = 1'b1;
          ctrl.cfgLoad  = 1'b1;
          ctrl.cfgSel   = SEL_STATUS;
          ctrl.tmrStart = 1'b1;
          ctrl.errClr   = 1'b1;
          nxt           = ST_WAIT_LOCK;
        end
        ST_WAIT_LOCK, ST_WAIT_OCLR, ST_WAIT_RELOCK: if (tick) begin
          if (waitOk) begin
            case (state)
              ST_WAIT_LOCK: begin
                ctrl.cfgLoad  = 1'b1;
                ctrl.cfgSel   = SEL_WR_A;
                ctrl.tmrStart = 1'b1;
                ctrl.tmrGap   = 1'b1;
                nxt           = ST_WR_A_SET;
              end
              ST_WAIT_OCLR: begin
                ctrl.cfgLoad  = 1'b1;
                ctrl.cfgSel   = SEL_STATUS;
                ctrl.tmrStart = 1'b1;
                nxt           = ST_WAIT_RELOCK;
              end
              default: nxt = ST_ON;
            endcase
          end else if (pollLast) begin
            ctrl.setRst = 1'b1;
            ctrl.errSet = 1'b1;
            ctrl.errVal = waitCode;
            nxt         = ST_IDLE;
          end else begin
            ctrl.tmrReload = 1'b1;
          end
        end
        ST_WR_A_SET, ST_WR_B_SET: if (tick) begin
          ctrl.weOn     = 1'b1;
          ctrl.tmrStart = 1'b1;
          ctrl.tmrGap   = 1'b1;
          nxt           = (state == ST_WR_A_SET) ? ST_WR_A_STB : ST_WR_B_STB;
        end
        ST_WR_A_STB: if (tick) begin
          ctrl.weOff    = 1'b1;
          ctrl.cfgLoad  = 1'b1;
          ctrl.cfgSel   = SEL_WR_B;
          ctrl.tmrStart = 1'b1;
          ctrl.tmrGap   = 1'b1;
          nxt           = ST_WR_B_SET;
        end
        ST_WR_B_STB: if (tick) begin
          ctrl.weOff    = 1'b1;
          ctrl.tmrStart = 1'b1;
          nxt           = ST_WAIT_OCLR;
        end
        ST_OFF: begin
          ctrl.setRst = 1'b1;
          nxt         = ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assign ready = (state == ST_ON);
  assign busy  = (state != ST_IDLE) && (state != ST_ON);

  AST_READY_ONLY_AFTER_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(state) == ST_WAIT_RELOCK && $past(pllLocked))); // R6

endmodule

// File: rtl/phy_pwrup_seq.sv
module phy_pwrup_seq
  import phy_pwrup_pkg::*;
#(
  parameter int POLL_CYCLES    = 2500,
  parameter int TIMEOUT_CYCLES = 1000000,
  parameter int WR_GAP_CYCLES  = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       powerOnReq,
  input  logic       powerOffReq,
  input  logic       pllLocked,
  input  logic       pllOutput,
  output logic       phyRst,
  output logic       laneIdle,
  output logic [5:0] cfgAddr,
  output logic [3:0] cfgData,
  output logic       cfgWe,
  output logic       ready,
  output logic       busy,
  output logic [1:0] errCode
);

  seqCtrl_t ctrl;
  logic     tick;
  logic     pollLast;

  phy_pwrup_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .powerOnReq(powerOnReq), .powerOffReq(powerOffReq),
    .pllLocked(pllLocked), .pllOutput(pllOutput),
    .tick(tick), .pollLast(pollLast),
    .ctrl(ctrl), .ready(ready), .busy(busy)
  );

  phy_pwrup_dp #(
    .POLL_CYCLES(POLL_CYCLES), .TIMEOUT_CYCLES(TIMEOUT_CYCLES), .WR_GAP_CYCLES(WR_GAP_CYCLES)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl),
    .tick(tick), .pollLast(pollLast),
    .phyRst(phyRst), .laneIdle(laneIdle),
    .cfgAddr(cfgAddr), .cfgData(cfgData), .cfgWe(cfgWe), .errCode(errCode)
  );

  AST_READY_PHY_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!phyRst && !laneIdle)); // R6

endmodule

// File: tb/phy_pwrup_seq_tb_top.sv
module phy_pwrup_seq_tb_top;

  localparam int POLL    = 4;
  localparam int TIMEOUT = 40;
  localparam int GAP     = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic powerOnReq = 1'b0, powerOffReq = 1'b0;
  logic pllLocked = 1'b0, pllOutput = 1'b1;
  logic phyRst, laneIdle, cfgWe, ready, busy;
  logic [5:0] cfgAddr;
  logic [3:0] cfgData;
  logic [1:0] errCode;

  int nChecks = 0, nFails = 0;
  int failStage = 0, lockDelay = 30;
  int wrCount = 0;
  logic [5:0] wrAddr [0:63];
  logic [3:0] wrData [0:63];
  int wrLen [0:63];
  int wrSetup [0:63];
  int phase = 0, cnt = 0, weRun = 0, fieldAge = 0;
  logic weSeen = 1'b0;
  logic [9:0] lastFields = '0;

  always #10 clk = ~clk;

  phy_pwrup_seq #(.POLL_CYCLES(POLL), .TIMEOUT_CYCLES(TIMEOUT), .WR_GAP_CYCLES(GAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .powerOnReq(powerOnReq), .powerOffReq(powerOffReq),
    .pllLocked(pllLocked), .pllOutput(pllOutput), .phyRst(phyRst), .laneIdle(laneIdle),
    .cfgAddr(cfgAddr), .cfgData(cfgData), .cfgWe(cfgWe), .ready(ready), .busy(busy),
    .errCode(errCode)
  );

  // PLL model: lock, drop on second write, output clears, relock
  always @(negedge clk) begin
    if (phyRst) begin
      phase <= 0; cnt <= 0; pllLocked <= 1'b0; pllOutput <= 1'b1;
    end else begin
      cnt <= cnt + 1;
      case (phase)
        0: if (cnt >= lockDelay && failStage != 1) begin pllLocked <= 1'b1; phase <= 1; end
        1: if (cfgWe && cfgAddr == 6'h12) begin pllLocked <= 1'b0; phase <= 2; cnt <= 0; end
        2: if (cnt >= 10 && failStage != 2) begin pllOutput <= 1'b0; phase <= 3; cnt <= 0; end
        3: if (cnt >= 10 && failStage != 3) begin pllLocked <= 1'b1; phase <= 4; end
        default: ;
      endcase
    end
  end

  // Write monitor: fields, strobe length, setup time
  always @(negedge clk) begin
    if ({cfgAddr, cfgData} != lastFields) fieldAge <= 1;
    else fieldAge <= fieldAge + 1;
    lastFields <= {cfgAddr, cfgData};
    if (cfgWe && !weSeen) begin
      wrAddr[wrCount % 64]  <= cfgAddr;
      wrData[wrCount % 64]  <= cfgData;
      wrSetup[wrCount % 64] <= fieldAge;
      weRun <= 1;
    end else if (cfgWe) begin
      weRun <= weRun + 1;
    end else if (weSeen) begin
      wrLen[wrCount % 64] <= weRun;
      wrCount <= wrCount + 1;
    end
    weSeen <= cfgWe;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulseOn();
    @(negedge clk) powerOnReq = 1'b1;
    @(negedge clk) powerOnReq = 1'b0;
  endtask

  task automatic pulseOff();
    @(negedge clk) powerOffReq = 1'b1;
    @(negedge clk) powerOffReq = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 500 && busy; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    check(phyRst == 1'b1, "R1 phyRst", phyRst, 1);
    check(laneIdle == 1'b1, "R1 laneIdle", laneIdle, 1);
    check(cfgWe == 1'b0 && cfgAddr == 6'h0 && cfgData == 4'h0, "R1 cfg port", {cfgWe, cfgAddr, cfgData}, 0);
    check(!ready && !busy && errCode == 2'd0, "R1 status", {ready, busy, errCode}, 0);
  endtask

  task automatic t_on_ok();
    int base;
    base = wrCount; failStage = 0; lockDelay = TIMEOUT - 6;  // R3 late lock still inside the limit
    pulseOn();
    check(!phyRst && !laneIdle, "R2 release", {phyRst, laneIdle}, 0);
    check(cfgAddr == 6'h10 && busy, "R2 lock view", {busy, cfgAddr}, 32'h50);
    waitIdle();
    check(ready && errCode == 2'd0, "R6 ready after relock", {ready, errCode}, 4);
    check(wrCount - base == 2, "R4 write count", wrCount - base, 2);
    check(wrAddr[base % 64] == 6'h10 && wrData[base % 64] == 4'h8, "R4 first write",
          {wrAddr[base % 64], wrData[base % 64]}, 32'h108);
    check(wrAddr[(base + 1) % 64] == 6'h12 && wrData[(base + 1) % 64] == 4'h8, "R4 second write",
          {wrAddr[(base + 1) % 64], wrData[(base + 1) % 64]}, 32'h128);
    check(wrLen[base % 64] == GAP && wrLen[(base + 1) % 64] == GAP, "R4 strobe length", wrLen[base % 64], GAP);
    check(wrSetup[(base + 1) % 64] == GAP, "R4 setup time", wrSetup[(base + 1) % 64], GAP);
    check(cfgAddr == 6'h10 && !pllOutput, "R6 R5 reselect after output clear", {pllOutput, cfgAddr}, 32'h10);
  endtask

  task automatic t_ignore_on();
    int base;
    base = wrCount;
    pulseOn();
    repeat (20) @(negedge clk);
    check(ready && !busy, "R10 ready kept", {ready, busy}, 2);
    check(wrCount == base, "R10 no write", wrCount - base, 0);
  endtask

  task automatic t_off();
    pulseOff();
    check(laneIdle && !phyRst && !ready, "R8 idle first", {laneIdle, phyRst, ready}, 4);
    @(negedge clk);
    check(phyRst && !busy, "R8 reset next", {phyRst, busy}, 2);
  endtask

  task automatic t_fail(input int stage);
    int n, base;
    base = wrCount; failStage = stage; lockDelay = 5;
    pulseOn();
    n = 0;
    while (errCode == 2'd0 && n < 600) begin @(negedge clk); n++; end
    check(errCode == 2'(stage), "R7 error code per stage", errCode, stage);
    check(phyRst && !busy && !ready, "R7 reset on timeout", {phyRst, busy, ready}, 4);
    if (stage == 1) begin
      check(n >= TIMEOUT - 2 && n <= TIMEOUT + 2, "R3 timeout length", n, TIMEOUT);
      check(wrCount == base, "R3 no write after lock fail", wrCount - base, 0);
    end else if (stage == 2) begin
      check(wrCount - base == 2, "R5 writes done before output wait", wrCount - base, 2);
    end else begin
      check(errCode == 2'd3, "R6 relock timeout code", errCode, 3);
    end
    repeat (5) @(negedge clk);
    check(errCode == 2'(stage), "R7 code held", errCode, stage);
  endtask

  task automatic t_err_clear();
    failStage = 0; lockDelay = 5;
    pulseOn();
    check(errCode == 2'd0, "R7 cleared by request", errCode, 0);
    waitIdle();
    check(ready, "R7 recovers", ready, 1);
  endtask

  task automatic t_abort();
    int base;
    failStage = 1; base = wrCount;
    pulseOn();
    repeat (10) @(negedge clk);
    pulseOff();
    check(laneIdle && !phyRst, "R9 abort idles lane", {laneIdle, phyRst}, 2);
    @(negedge clk);
    check(phyRst && !busy && errCode == 2'd0, "R9 abort resets", {phyRst, busy, errCode}, 4);
    repeat (20) @(negedge clk);
    check(wrCount == base && !busy, "R9 no write after abort", wrCount - base, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_on_ok();
    t_ignore_on();
    t_off();
    t_fail(1);
    t_fail(2);
    t_fail(3);
    t_err_clear();
    t_off();
    t_abort();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule